// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO with Producer-Side Clear

This block moves fixed-width data words, 16-bit pixels by default, from a producer running on one clock to a consumer running on an unrelated clock. The producer pushes words with a write strobe and holds off while the full flag is high. The consumer pulls words with a read strobe while the empty flag is low. Each side keeps its own pointer. The pointers cross between the domains in Gray code through flip-flop synchronizer chains, so a pointer sampled in the other domain is always either its old value or its new value.

The producer can flush the buffer with a one-cycle clear pulse, for example at the start of every frame. The clear resets the write pointer at once. It then runs a request and acknowledge handshake through synchronizers into the read domain, where it resets the read pointer. While the handshake is in progress the write side reports full and the read side reports empty. New data is therefore accepted only after both pointers are back at the start.

Top module: `gray_async_fifo`

## Requirements
- R1: The FIFO holds exactly 2**ADDR_W words (16 by default). With no reads, `wr_full` is still low after 15 accepted writes and is high right after the write edge that stores the 16th word.
- R2: A read accepted at a read-clock edge (`rd_en` high and `rd_empty` low) loads the oldest stored word onto `rd_data` at that same edge. Words leave in the order they were written.
- R3: A write attempted while `wr_full` is high is dropped. The write pointer does not move, no stored word is overwritten, and the dropped word never appears on the read side.
- R4: A read attempted while `rd_empty` is high is dropped. `rd_data` keeps its value and no later word is skipped.
- R5: Both pointers count in Gray code and change by at most one bit per clock, except when a clear resets them. Ordering and flags stay correct over a stream that wraps the pointers several times.
- R6: With SYNC_STAGES = 2, `rd_empty` falls at the third read edge after the write edge that made the FIFO non-empty. `wr_full` falls at the third write edge after the read edge that freed an entry. After the last word is read, `rd_empty` rises at that same read edge.
- R7: After reset, `wr_full` is 0, `rd_empty` is 1 and `rd_data` is 0.
- R8: `wr_clear` (write domain, active high) resets the write pointer at the next write edge and drops any write in that cycle. Once the clear completes, the FIFO is empty and the first word written afterwards is the first word read.
- R9: From the write edge that samples `wr_clear` until the read side has acknowledged it, `wr_full` stays high. From the moment the read side sees the clear (SYNC_STAGES read edges later), `rd_empty` is high, reads are dropped and the read pointer is held at its start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Word to store |
| wr_clear | input | 1 | Flush request, one write-clock pulse |
| wr_full | output | 1 | No free entry, or a clear is in progress |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Word loaded by the last accepted read |
| rd_empty | output | 1 | No valid word, or a clear is being applied |

## Verification
The bench drives both ports from one clock, so every latency is a fixed count of edges. Read data is due at the edge that accepts the read. `rd_empty` falls three edges after a write. `wr_full` rises at the filling write and falls three edges after a read. After a clear, `wr_full` is high at the next edge and `rd_empty` is forced high three edges after the clear. Inputs change and outputs are sampled on the falling edge, and each check is placed on the falling edge that follows the exact rising edge at which its result is due. The release of a clear takes a longer handshake, so the bench polls for it with an upper bound and checks only that it happens.

// File: rtl/afifo_pkg.sv
// Shared definitions for the dual-clock FIFO.
// Assumes pointer widths never exceed GRAY_CALC_W bits.
package afifo_pkg;

    localparam int GRAY_CALC_W = 32;

    // Phases of the producer-side clear handshake.
    typedef enum logic [1:0] {
        CLR_IDLE    = 2'd0,
        CLR_REQ     = 2'd1,
        CLR_RELEASE = 2'd2
    } clr_phase_t;

    // Reflected binary to Gray conversion.
    function automatic logic [GRAY_CALC_W-1:0] to_gray(input logic [GRAY_CALC_W-1:0] bin);
        return bin ^ (bin >> 1);
    endfunction

endpackage

// File: rtl/afifo_sync.sv
// Multi-stage flip-flop synchronizer for a bus whose bits may change
// only one at a time (Gray pointers) or for single-bit levels.
// Assumes STAGES >= 2 and a synchronous active-low reset in the destination domain.
module afifo_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] taps;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            logic [WIDTH-1:0] stage_d;
            logic [WIDTH-1:0] stage_r;

            if (g == 0) begin : g_first
                assign stage_d = d;
            end else begin : g_next
                assign stage_d = taps[g-1];
            end

            // One register stage of the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_r <= '0;
                end else begin
                    stage_r <= stage_d;
                end
            end

            assign taps[g] = stage_r;
        end
    endgenerate

    assign q = taps[STAGES-1];

endmodule

// File: rtl/afifo_mem.sv
// Storage array: written on the producer clock, read into a registered
// output on the consumer clock.
// Assumes the pointer logic never writes an entry that is still unread.
module afifo_mem #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              w_en,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Store an accepted word.
    always_ff @(posedge wclk) begin
        if (w_en) begin
            cells[waddr] <= wdata;
        end
    end

    // Load the oldest word on an accepted read.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rdata <= '0;
        end else if (r_en) begin
            rdata <= cells[raddr];
        end
    end

endmodule

// File: rtl/afifo_wr_ctrl.sv
// Producer-side control: write pointer (binary and Gray), registered full
// flag, and the clear handshake toward the consumer domain.
// Assumes rgray_s and ack_s are already synchronized to wclk, and ADDR_W >= 2.
module afifo_wr_ctrl
    import afifo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              wr_en,
    input  logic              wr_clear,
    input  logic [ADDR_W:0]   rgray_s,
    input  logic              ack_s,
    output logic              wr_full,
    output logic              w_accept,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output logic              clr_req
);

    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_next;
    logic [PW-1:0] wgray_next;
    logic [PW-1:0] full_pattern;
    logic          full_r;
    logic          busy;
    clr_phase_t    clr_phase;

    assign busy     = (clr_phase != CLR_IDLE);
    assign wr_full  = full_r | busy;
    assign w_accept = wr_en & ~wr_full & ~wr_clear;
    assign waddr    = wbin[ADDR_W-1:0];
    assign clr_req  = (clr_phase == CLR_REQ);

    // Next pointer values and the read pointer pattern that means full.
    always_comb begin
        wbin_next    = wbin + PW'(w_accept);
        wgray_next   = PW'(to_gray(GRAY_CALC_W'(wbin_next)));
        full_pattern = {~rgray_s[PW-1 -: 2], rgray_s[PW-3:0]};
    end

    // Write pointer and full flag.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            wbin   <= '0;
            wgray  <= '0;
            full_r <= 1'b0;
        end else if (wr_clear) begin
            wbin   <= '0;
            wgray  <= '0;
            full_r <= 1'b0;
        end else begin
            wbin   <= wbin_next;
            wgray  <= wgray_next;
            full_r <= (wgray_next == full_pattern);
        end
    end

    // Clear handshake: request until acknowledged, then wait for the ack to drop.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            clr_phase <= CLR_IDLE;
        end else begin
            unique case (clr_phase)
                CLR_IDLE:    if (wr_clear) clr_phase <= CLR_REQ;
                CLR_REQ:     if (ack_s)    clr_phase <= CLR_RELEASE;
                CLR_RELEASE: if (!ack_s)   clr_phase <= CLR_IDLE;
                default:                   clr_phase <= CLR_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/afifo_rd_ctrl.sv
// Consumer-side control: read pointer (binary and Gray), registered empty
// flag, and the response to a synchronized clear request.
// Assumes wgray_s and clr_s are already synchronized to rclk.
module afifo_rd_ctrl
    import afifo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wgray_s,
    input  logic              clr_s,
    output logic              rd_empty,
    output logic              r_accept,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic              clr_ack
);

    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_next;
    logic [PW-1:0] rgray_next;
    logic          empty_r;
    logic          clr_hold;

    assign rd_empty = empty_r | clr_s | clr_hold;
    assign r_accept = rd_en & ~rd_empty;
    assign raddr    = rbin[ADDR_W-1:0];
    assign clr_ack  = clr_hold;

    // Next read pointer values.
    always_comb begin
        rbin_next  = rbin + PW'(r_accept);
        rgray_next = PW'(to_gray(GRAY_CALC_W'(rbin_next)));
    end

    // Read pointer, empty flag and clear acknowledge.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rbin     <= '0;
            rgray    <= '0;
            empty_r  <= 1'b1;
            clr_hold <= 1'b0;
        end else begin
            clr_hold <= clr_s;
            if (clr_s) begin
                rbin    <= '0;
                rgray   <= '0;
                empty_r <= 1'b1;
            end else begin
                rbin    <= rbin_next;
                rgray   <= rgray_next;
                empty_r <= (rgray_next == wgray_s);
            end
        end
    end

endmodule

// File: rtl/gray_async_fifo.sv
// Dual-clock FIFO with Gray-coded pointers and a producer-side clear.
// Assumes ADDR_W >= 2, SYNC_STAGES >= 2 and a one-cycle wr_clear pulse.
module gray_async_fifo #(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_clear,
    output logic              wr_full,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty
);

    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     wgray;
    logic [PW-1:0]     rgray;
    logic [PW-1:0]     rgray_w;
    logic [PW-1:0]     wgray_r;
    logic              w_accept;
    logic              r_accept;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic              clr_req;
    logic              clr_ack;
    logic              ack_w;
    logic              rd_clr_seen;

    afifo_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
        .wclk     (wr_clk),
        .wrst_n   (wr_rst_n),
        .wr_en    (wr_en),
        .wr_clear (wr_clear),
        .rgray_s  (rgray_w),
        .ack_s    (ack_w),
        .wr_full  (wr_full),
        .w_accept (w_accept),
        .waddr    (waddr),
        .wgray    (wgray),
        .clr_req  (clr_req)
    );

    afifo_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
        .rclk     (rd_clk),
        .rrst_n   (rd_rst_n),
        .rd_en    (rd_en),
        .wgray_s  (wgray_r),
        .clr_s    (rd_clr_seen),
        .rd_empty (rd_empty),
        .r_accept (r_accept),
        .raddr    (raddr),
        .rgray    (rgray),
        .clr_ack  (clr_ack)
    );

    afifo_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_rptr_to_wr (
        .clk (wr_clk), .rst_n (wr_rst_n), .d (rgray), .q (rgray_w)
    );

    afifo_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ack_to_wr (
        .clk (wr_clk), .rst_n (wr_rst_n), .d (clr_ack), .q (ack_w)
    );

    afifo_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_wptr_to_rd (
        .clk (rd_clk), .rst_n (rd_rst_n), .d (wgray), .q (wgray_r)
    );

    afifo_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_clr_to_rd (
        .clk (rd_clk), .rst_n (rd_rst_n), .d (clr_req), .q (rd_clr_seen)
    );

    afifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wclk   (wr_clk),
        .w_en   (w_accept),
        .waddr  (waddr),
        .wdata  (wr_data),
        .rclk   (rd_clk),
        .rrst_n (rd_rst_n),
        .r_en   (r_accept),
        .raddr  (raddr),
        .rdata  (rd_data)
    );

endmodule

// File: rtl/gray_async_fifo_chk.sv
// Property checker for gray_async_fifo, attached by bind below.
// Observes ports and the Gray pointers of both domains.
module gray_async_fifo_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input logic              wr_clk,
    input logic              wr_rst_n,
    input logic              wr_en,
    input logic              wr_clear,
    input logic              wr_full,
    input logic [ADDR_W:0]   wgray,
    input logic              rd_clk,
    input logic              rd_rst_n,
    input logic              rd_en,
    input logic              rd_empty,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W:0]   rgray,
    input logic              rd_clr_seen
);

    AST_WGRAY_ONE_STEP: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !$past(wr_clear) |-> ($countones(wgray ^ $past(wgray)) <= 1)); // R5

    AST_RGRAY_ONE_STEP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !$past(rd_clr_seen) |-> ($countones(rgray ^ $past(rgray)) <= 1)); // R5

    AST_NO_WRITE_WHEN_FULL: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && wr_full && !wr_clear) |=> $stable(wgray)); // R3

    AST_NO_READ_WHEN_EMPTY: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_en && rd_empty && !rd_clr_seen) |=> ($stable(rgray) && $stable(rd_data))); // R4

    AST_CLEAR_RESTARTS_WPTR: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_clear |=> (wgray == '0)); // R8

    AST_CLEAR_BLOCKS_WRITES: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_clear |=> wr_full); // R9

    AST_RD_CLEAR_RESETS_RPTR: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_clr_seen |=> (rgray == '0)); // R9

endmodule

bind gray_async_fifo gray_async_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .wr_clk      (wr_clk),
    .wr_rst_n    (wr_rst_n),
    .wr_en       (wr_en),
    .wr_clear    (wr_clear),
    .wr_full     (wr_full),
    .wgray       (wgray),
    .rd_clk      (rd_clk),
    .rd_rst_n    (rd_rst_n),
    .rd_en       (rd_en),
    .rd_empty    (rd_empty),
    .rd_data     (rd_data),
    .rgray       (rgray),
    .rd_clr_seen (rd_clr_seen)
);

// File: tb/gray_async_fifo_tb.sv
// Directed bench. Both ports share one 250 MHz clock, so latencies are exact.
// Inputs change and outputs are sampled on the falling edge.
module gray_async_fifo_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_clear = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_full;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        rd_empty;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    gray_async_fifo #(.DATA_W(16), .ADDR_W(4), .SYNC_STAGES(2)) u_dut (
        .wr_clk   (clk),
        .wr_rst_n (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_clear (wr_clear),
        .wr_full  (wr_full),
        .rd_clk   (clk),
        .rd_rst_n (rst_n),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_empty (rd_empty)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7", "full after reset",    32'(wr_full),  32'd0);
        check("R7", "empty after reset",   32'(rd_empty), 32'd1);
        check("R7", "rd_data after reset", 32'(rd_data), 32'd0);
    endtask

    task automatic t_empty_latency();
        wr_en = 1'b1; wr_data = 16'hA5C3;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R6", "empty two edges after write", 32'(rd_empty), 32'd1);
        @(negedge clk);
        check("R6", "empty three edges after write", 32'(rd_empty), 32'd0);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R2", "single word data", 32'(rd_data), 32'hA5C3);
        check("R6", "empty after last word", 32'(rd_empty), 32'd1);
    endtask

    task automatic t_fill_and_drain();
        wr_en = 1'b1;
        for (int i = 0; i < 16; i++) begin
            wr_data = 16'(16'h1000 + i);
            @(negedge clk);
            if (i == 14) check("R1", "full after 15 writes", 32'(wr_full), 32'd0);
        end
        check("R1", "full after 16 writes", 32'(wr_full), 32'd1);
        wr_data = 16'hDEAD;
        @(negedge clk);
        wr_en = 1'b0;
        check("R3", "full held after dropped write", 32'(wr_full), 32'd1);
        repeat (2) @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R2", "first word", 32'(rd_data), 32'h1000);
        @(negedge clk);
        @(negedge clk);
        check("R6", "full two edges after read", 32'(wr_full), 32'd1);
        @(negedge clk);
        check("R6", "full three edges after read", 32'(wr_full), 32'd0);
        rd_en = 1'b1;
        for (int i = 1; i < 16; i++) begin
            @(negedge clk);
            check("R2", "drain order", 32'(rd_data), 32'(16'h1000 + i));
        end
        rd_en = 1'b0;
        check("R3", "empty after 16 reads, dropped word absent", 32'(rd_empty), 32'd1);
    endtask

    task automatic t_read_when_empty();
        rd_en = 1'b1;
        repeat (3) @(negedge clk);
        rd_en = 1'b0;
        check("R4", "rd_data held on empty reads", 32'(rd_data), 32'h100F);
        check("R4", "still empty", 32'(rd_empty), 32'd1);
        wr_en = 1'b1; wr_data = 16'h2222;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (4) @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R4", "next word not skipped", 32'(rd_data), 32'h2222);
    endtask

    task automatic t_stream();
        int  wcnt = 0;
        int  rcnt = 0;
        bit  pend = 1'b0;
        for (int cyc = 0; cyc < 800 && rcnt < 64; cyc++) begin
            if (pend) begin
                check("R5", "stream order", 32'(rd_data), 32'(16'h3000 + rcnt));
                rcnt++;
            end
            wr_en   = (wcnt < 64) && !wr_full && (cyc % 3 != 2);
            wr_data = 16'(16'h3000 + wcnt);
            if (wr_en) wcnt++;
            rd_en = !rd_empty && (cyc % 5 != 4);
            pend  = rd_en;
            @(negedge clk);
        end
        wr_en = 1'b0;
        rd_en = 1'b0;
        check("R5", "stream word count", 32'(rcnt), 32'd64);
        check("R5", "empty after stream", 32'(rd_empty), 32'd1);
    endtask

    task automatic t_clear();
        logic [15:0] last_rd;
        bit          released = 1'b0;
        last_rd = rd_data;
        wr_en = 1'b1;
        for (int i = 0; i < 5; i++) begin
            wr_data = 16'(16'h4000 + i);
            @(negedge clk);
        end
        wr_data = 16'h7777; wr_clear = 1'b1;
        @(negedge clk);
        wr_clear = 1'b0; wr_en = 1'b0;
        check("R9", "full right after clear", 32'(wr_full), 32'd1);
        repeat (3) @(negedge clk);
        check("R9", "empty forced three edges after clear", 32'(rd_empty), 32'd1);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R9", "read during clear dropped", 32'(rd_data), 32'(last_rd));
        @(negedge clk);
        check("R9", "full held during handshake", 32'(wr_full), 32'd1);
        for (int k = 0; k < 40 && !released; k++) begin
            if (!wr_full) released = 1'b1;
            else @(negedge clk);
        end
        check("R9", "clear handshake completes", 32'(released), 32'd1);
        check("R8", "empty after clear", 32'(rd_empty), 32'd1);
        wr_en = 1'b1; wr_data = 16'h1234;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (4) @(negedge clk);
        check("R8", "new word visible", 32'(rd_empty), 32'd0);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R8", "first word after clear", 32'(rd_data), 32'h1234);
        check("R8", "only one word after clear", 32'(rd_empty), 32'd1);
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_empty_latency();
        t_fill_and_drain();
        t_read_when_empty();
        t_stream();
        t_clear();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule